// File: doc/BRIEF.md
# Maskable BCD Calendar Alarm Comparator

The block watches a running BCD calendar and a sub-second counter and raises an alarm when they agree with a programmed alarm value. Each alarm value is one 32-bit word. It holds seconds, minutes, hours with an AM/PM bit, and a day field. Each of the four calendar groups has its own don't-care bit. The day field is compared either with the day of the month or with the weekday. A separate 15-bit sub-second value is compared only on a programmable number of its low bits.

A parameter sets the number of independent alarm units, two by default. They share the calendar inputs. Each unit has its own alarm word, sub-second value, mask count, enable, clear and outputs. The comparison is sampled on the clock edge where the sub-second tick strobe is high. A hit produces a one-cycle match pulse, which can be routed to interrupt or pin logic. The same hit sets a sticky flag, which stays set until the clear input drops it.

Top module: `calendar_alarm`

## Requirements
- R1: The alarm word holds seconds in [6:0] and minutes in [14:8]. A zero at bit 7 makes the seconds count toward the match, and a zero at bit 15 does the same for the minutes. A one at either bit removes that field from the comparison.
- R2: Hours sit in [21:16], with the hour don't-care at bit 23. The day field sits in [29:24], with the day don't-care at bit 31. When bits 7, 15, 23 and 31 are all one, the calendar part always matches.
- R3: Bit 30 selects what the day field is compared with. A 0 compares it with the day of the month (mday_i). A 1 compares it with the weekday (wday_i, zero-extended to 6 bits).
- R4: When hour12_i is 1, bit 22 must equal pm_i for the hour group to match. When hour12_i is 0, bit 22 is ignored.
- R5: A sub-second mask count of 0 ignores the sub-second value. A count k from 1 to 14 compares bits [k-1:0] only. A count of 15 compares all of bits [14:0].
- R6: Matching is evaluated only on a clock edge where tick_i is 1. match_o goes high in the cycle after such an edge. It stays high for exactly one cycle for each hitting tick.
- R7: flag_o is set together with match_o and stays set until clear_i is raised. If a hit and a clear occur on the same edge, the flag ends up set.
- R8: While enable_i of a unit is 0, that unit produces no match_o and does not set its flag. A flag that is already set stays set.
- R9: Alarm units are independent. Each uses only its own word, sub-second value, count, enable and clear.
- R10: While rst_ni is low, all flags and match pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sub-second tick strobe; comparison is sampled when high |
| hour12_i | input | 1 | 1 = 12-hour mode, the AM/PM bit takes part in the hour compare |
| sec_i | input | 7 | Current seconds, BCD |
| min_i | input | 7 | Current minutes, BCD |
| hour_i | input | 6 | Current hours, BCD |
| pm_i | input | 1 | Current PM indicator |
| mday_i | input | 6 | Current day of month, BCD |
| wday_i | input | 3 | Current weekday |
| subsec_i | input | 15 | Current sub-second count |
| alarm_word_i | input | NUM_ALARMS*32 | Alarm words, unit n in slice [n*32 +: 32] |
| alarm_sub_i | input | NUM_ALARMS*SUB_W | Sub-second alarm values |
| sub_cnt_i | input | NUM_ALARMS*CNT_W | Sub-second compare bit counts |
| enable_i | input | NUM_ALARMS | Per-unit enable |
| clear_i | input | NUM_ALARMS | Per-unit flag clear |
| flag_o | output | NUM_ALARMS | Sticky alarm flags |
| match_o | output | NUM_ALARMS | One-cycle match pulses |

## Verification
The hardest case to reach is a single edge that carries both a hit and a clear: the flag must end up set. To reach it, the bench first sets the flag and then drives tick and clear together on one cycle. A second hard case is the sub-second boundary. The mask count is swept across the bit where a chosen alarm value first disagrees with the counter, so that one count matches and the next does not. Count 14 and count 15 are also set against values that differ only in bit 14.

// File: rtl/calalarm_pkg.sv
package calalarm_pkg;
  localparam int WORD_W   = 32;
  localparam int SEC_W    = 7;
  localparam int MIN_W    = 7;
  localparam int HOUR_W   = 6;
  localparam int DAY_W    = 6;
  localparam int WDAY_W   = 3;

  localparam int SEC_LSB  = 0;
  localparam int SEC_DC   = 7;
  localparam int MIN_LSB  = 8;
  localparam int MIN_DC   = 15;
  localparam int HOUR_LSB = 16;
  localparam int PM_BIT   = 22;
  localparam int HOUR_DC  = 23;
  localparam int DAY_LSB  = 24;
  localparam int WSEL_BIT = 30;
  localparam int DAY_DC   = 31;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [MIN_W-1:0]  min;
    logic [HOUR_W-1:0] hour;
    logic              pm;
    logic [DAY_W-1:0]  mday;
    logic [WDAY_W-1:0] wday;
  } cal_t;
endpackage

// File: rtl/alarm_cal_cmp.sv
module alarm_cal_cmp
  import calalarm_pkg::*;
(
  input  logic              hour12_i,
  input  cal_t              now_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              cal_hit_o
);
  logic sec_ok, min_ok, hour_ok, day_ok;
  logic [DAY_W-1:0] day_ref;

  always_comb begin
    sec_ok  = word_i[SEC_DC] | (word_i[SEC_LSB +: SEC_W] == now_i.sec);
    min_ok  = word_i[MIN_DC] | (word_i[MIN_LSB +: MIN_W] == now_i.min);
    hour_ok = word_i[HOUR_DC] |
              ((word_i[HOUR_LSB +: HOUR_W] == now_i.hour) &
               (~hour12_i | (word_i[PM_BIT] == now_i.pm)));
    day_ref = word_i[WSEL_BIT] ? {{(DAY_W-WDAY_W){1'b0}}, now_i.wday} : now_i.mday;
    day_ok  = word_i[DAY_DC] | (word_i[DAY_LSB +: DAY_W] == day_ref);
    cal_hit_o = sec_ok & min_ok & hour_ok & day_ok;
  end
endmodule

// File: rtl/alarm_sub_cmp.sv
module alarm_sub_cmp #(
  parameter int SUB_W = 15,
  parameter int CNT_W = $clog2(SUB_W + 1)
) (
  input  logic [SUB_W-1:0] now_i,
  input  logic [SUB_W-1:0] ref_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             sub_hit_o
);
  logic [SUB_W-1:0] care;

  // bit b is compared when b < count
  for (genvar b = 0; b < SUB_W; b++) begin : g_care
    assign care[b] = (b < int'(cnt_i));
  end

  assign sub_hit_o = ~|((now_i ^ ref_i) & care);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import calalarm_pkg::*;
#(
  parameter int SUB_W = 15,
  parameter int CNT_W = $clog2(SUB_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hour12_i,
  input  cal_t              now_i,
  input  logic [SUB_W-1:0]  subsec_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SUB_W-1:0]  sub_ref_i,
  input  logic [CNT_W-1:0]  sub_cnt_i,
  input  logic              en_i,
  input  logic              clear_i,
  output logic              flag_o,
  output logic              match_o
);
  logic cal_hit, sub_hit, hit;
  logic flag_q, match_q;

  alarm_cal_cmp u_cal (
    .hour12_i (hour12_i),
    .now_i    (now_i),
    .word_i   (word_i),
    .cal_hit_o(cal_hit)
  );

  alarm_sub_cmp #(.SUB_W(SUB_W), .CNT_W(CNT_W)) u_sub (
    .now_i    (subsec_i),
    .ref_i    (sub_ref_i),
    .cnt_i    (sub_cnt_i),
    .sub_hit_o(sub_hit)
  );

  assign hit = en_i & tick_i & cal_hit & sub_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      match_q <= hit;
      // a hit on the clearing edge wins so no event is lost
      if (hit)          flag_q <= 1'b1;
      else if (clear_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign match_o = match_q;

  p_match_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |-> $past(tick_i));
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !match_q);
  p_flag_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> match_q);
  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clear_i) |=> flag_q);
  p_all_dont_care_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && word_i[SEC_DC] && word_i[MIN_DC] && word_i[HOUR_DC] &&
     word_i[DAY_DC] && sub_cnt_i == '0) |=> match_q);
  p_full_sub_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sub_cnt_i) == SUB_W && subsec_i != sub_ref_i) |-> !sub_hit);
  p_weekday_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_i[WSEL_BIT] && !word_i[DAY_DC] &&
     word_i[DAY_LSB +: DAY_W] != {{(DAY_W-WDAY_W){1'b0}}, now_i.wday}) |-> !cal_hit);
endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
  import calalarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2,
  parameter int SUB_W      = 15,
  parameter int CNT_W      = $clog2(SUB_W + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         hour12_i,
  input  logic [SEC_W-1:0]             sec_i,
  input  logic [MIN_W-1:0]             min_i,
  input  logic [HOUR_W-1:0]            hour_i,
  input  logic                         pm_i,
  input  logic [DAY_W-1:0]             mday_i,
  input  logic [WDAY_W-1:0]            wday_i,
  input  logic [SUB_W-1:0]             subsec_i,
  input  logic [NUM_ALARMS*WORD_W-1:0] alarm_word_i,
  input  logic [NUM_ALARMS*SUB_W-1:0]  alarm_sub_i,
  input  logic [NUM_ALARMS*CNT_W-1:0]  sub_cnt_i,
  input  logic [NUM_ALARMS-1:0]        enable_i,
  input  logic [NUM_ALARMS-1:0]        clear_i,
  output logic [NUM_ALARMS-1:0]        flag_o,
  output logic [NUM_ALARMS-1:0]        match_o
);
  cal_t now;
  assign now = '{sec: sec_i, min: min_i, hour: hour_i, pm: pm_i,
                 mday: mday_i, wday: wday_i};

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_unit
    alarm_unit #(.SUB_W(SUB_W), .CNT_W(CNT_W)) u_alarm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .hour12_i (hour12_i),
      .now_i    (now),
      .subsec_i (subsec_i),
      .word_i   (alarm_word_i[n*WORD_W +: WORD_W]),
      .sub_ref_i(alarm_sub_i[n*SUB_W +: SUB_W]),
      .sub_cnt_i(sub_cnt_i[n*CNT_W +: CNT_W]),
      .en_i     (enable_i[n]),
      .clear_i  (clear_i[n]),
      .flag_o   (flag_o[n]),
      .match_o  (match_o[n])
    );
  end
endmodule

// File: tb/tb_calendar_alarm.sv
`timescale 1ns/1ps
module tb_calendar_alarm;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        tick, h12;
  logic [6:0]  sec, mn;
  logic [5:0]  hr;
  logic        pm;
  logic [5:0]  mday;
  logic [2:0]  wday;
  logic [14:0] subsec;
  logic [63:0] word;
  logic [29:0] asub;
  logic [7:0]  cnt;
  logic [1:0]  en, clr, flag, match;

  calendar_alarm dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hour12_i(h12),
    .sec_i(sec), .min_i(mn), .hour_i(hr), .pm_i(pm), .mday_i(mday), .wday_i(wday),
    .subsec_i(subsec), .alarm_word_i(word), .alarm_sub_i(asub), .sub_cnt_i(cnt),
    .enable_i(en), .clear_i(clr), .flag_o(flag), .match_o(match)
  );

  typedef struct packed {
    logic ms; logic [6:0] asec; logic mm; logic [6:0] amin;
    logic mh; logic apm; logic [5:0] ahour;
    logic md; logic wsel; logic [5:0] aday;
    logic [14:0] as; logic [3:0] k; logic h12; logic exp;
  } vec_t;

  // fixed time: 11:30:45 PM, day 15, weekday 3, sub-second 0x1234
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b1},
    '{1'b0,7'h44,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b0},
    '{1'b1,7'h44,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h31,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b0},
    '{1'b1,7'h00,1'b1,7'h00,1'b1,1'b0,6'h00,1'b1,1'b0,6'h00,15'h0000,4'd0, 1'b1,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b1,6'h03,15'h1234,4'd15,1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b1,6'h15,15'h1234,4'd15,1'b0,1'b0},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h16,15'h1234,4'd15,1'b0,1'b0},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b0,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b1,1'b0},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b0,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b1,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b1,1'b1,6'h12,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h12,1'b0,1'b0,6'h15,15'h1234,4'd15,1'b0,1'b0},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h7FF4,4'd4, 1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h7FF4,4'd6, 1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h7FF4,4'd7, 1'b0,1'b0},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h5234,4'd15,1'b0,1'b0},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h5234,4'd14,1'b0,1'b1},
    '{1'b0,7'h45,1'b0,7'h30,1'b0,1'b1,6'h11,1'b0,1'b0,6'h15,15'h0000,4'd0, 1'b0,1'b1}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load0(vec_t v);
    word[31:0] = {v.md, v.wsel, v.aday, v.mh, v.apm, v.ahour, v.mm, v.amin, v.ms, v.asec};
    asub[14:0] = v.as;
    cnt[3:0]   = v.k;
    h12        = v.h12;
  endtask

  // clear unit 0, then one tick; sample outputs one cycle after the tick edge
  task automatic apply0(vec_t v, string req);
    @(negedge clk); load0(v); clr = 2'b01; tick = 1'b0;
    @(negedge clk); clr = 2'b00; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk({req, " match0"}, {31'd0, match[0]}, {31'd0, v.exp});
    chk({req, " flag0"},  {31'd0, flag[0]},  {31'd0, v.exp});
  endtask

  task automatic tick_once(logic [1:0] c);
    @(negedge clk); tick = 1'b1; clr = c;
    @(negedge clk); tick = 1'b0; clr = 2'b00;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; h12 = 1'b0; clr = 2'b00; en = 2'b00;
    sec = 7'h45; mn = 7'h30; hr = 6'h11; pm = 1'b1; mday = 6'h15; wday = 3'd3;
    subsec = 15'h1234; word = '0; asub = '0; cnt = '0;
    // unit 1: everything don't-care, but disabled during the table
    word[63:32] = 32'h8080_8080; cnt[7:4] = 4'd0;
    repeat (3) @(negedge clk);
    chk("R10 flag in reset", {30'd0, flag}, 32'd0);
    chk("R10 match in reset", {30'd0, match}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flag after reset", {30'd0, flag}, 32'd0);
    en = 2'b01;

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i < 4)       tag = "R1";
      else if (i == 4) tag = "R2";
      else if (i < 8)  tag = "R3";
      else if (i < 11) tag = "R4";
      else if (i < 13) tag = "R2 hour";
      else             tag = "R5";
      apply0(VEC[i], tag);
    end
    chk("R9 disabled unit1 untouched", {31'd0, flag[1]}, 32'd0);

    // R6: matching config without tick gives nothing
    apply0(VEC[0], "R6 setup");
    @(negedge clk); clr = 2'b01;
    @(negedge clk); clr = 2'b00;
    repeat (3) @(negedge clk);
    chk("R6 no tick no match", {31'd0, match[0]}, 32'd0);
    chk("R7 clear drops flag", {31'd0, flag[0]}, 32'd0);
    tick_once(2'b00);
    chk("R6 match after tick", {31'd0, match[0]}, 32'd1);
    @(negedge clk);
    chk("R6 single-cycle pulse", {31'd0, match[0]}, 32'd0);
    chk("R7 flag sticky", {31'd0, flag[0]}, 32'd1);
    // R7: hit and clear on the same edge
    tick_once(2'b01);
    chk("R7 set wins over clear", {31'd0, flag[0]}, 32'd1);

    // R8: disabled, flag held, no pulse
    en = 2'b00;
    tick_once(2'b00);
    chk("R8 disabled no match", {31'd0, match[0]}, 32'd0);
    chk("R8 disabled flag held", {31'd0, flag[0]}, 32'd1);
    @(negedge clk); clr = 2'b01;
    @(negedge clk); clr = 2'b00;
    tick_once(2'b00);
    chk("R8 disabled flag not set", {31'd0, flag[0]}, 32'd0);

    // R9: only unit 1 enabled
    en = 2'b10;
    tick_once(2'b00);
    chk("R9 unit1 match", {31'd0, match[1]}, 32'd1);
    chk("R9 unit1 flag", {31'd0, flag[1]}, 32'd1);
    chk("R9 unit0 quiet", {31'd0, flag[0]}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule